// File: doc/BRIEF.md
# Reference-Clock Failure Monitor with Sticky Clock Switchover

This block supervises an external clock input by timing it against a free-running on-chip reference clock. Every level change of the external clock, rising or falling, restarts a small timeout counter that runs on the reference clock. If the counter reaches its limit, the external clock is declared dead. The system clock output then moves permanently onto the reference clock and an interrupt flag is raised.

The switch is one-way. Later activity on the external clock is ignored until a reset. A configuration input turns the monitor off to save power. While it is off and no failure has been latched, the reference oscillator enable is dropped and the system clock is simply the external clock. Software clears the interrupt flag by writing one. Neither clearing the flag nor setting the disable input undoes a switch that has already happened.

All control logic runs in the reference clock domain with a synchronous active-high reset. The external clock reaches it only through a synchronizer.

Top module: `owd_monitor`

## Requirements
- R1: After reset, `src_is_ref` = 0, `irq` = 0, `osc_en` = 1, and `sys_clk` follows `ext_clk`.
- R2: Both rising and falling transitions of `ext_clk` restart the timeout. They are seen through a two-stage synchronizer, so detection lags by a fixed number of cycles. If successive transitions are at most 16 reference cycles apart, no failure is declared.
- R3: While `cfg_disable` = 1 and no failure is latched, `osc_en` = 0 and the timeout is held at zero. No failure is declared however long `ext_clk` stays static, and `sys_clk` follows `ext_clk`.
- R4: With the monitor enabled, `src_is_ref` rises on the reference edge that completes 16 consecutive reference cycles without a detected transition. A gap of 17 or more cycles between transitions therefore causes a failure.
- R5: Once `src_is_ref` = 1, it stays 1 until reset, whatever `ext_clk` does.
- R6: `irq` is set on the same edge on which `src_is_ref` rises. It stays set until `irq_clr` = 1 is sampled on a reference edge. If a failure and a clear occur on the same edge, the set wins.
- R7: Clearing `irq` leaves `src_is_ref` unchanged.
- R8: `sys_clk` shows the external clock only until failure. On the failure edge the external path is gated off at once. The reference path opens on the second falling reference edge after it. `sys_clk` stays low in between.
- R9: Asserting `cfg_disable` after a failure leaves `osc_en` = 1 and `src_is_ref` = 1.
- R10: A reset after a failure returns the system clock to the external source (`src_is_ref` = 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock; all control logic runs on it |
| ext_clk | input | 1 | Supervised external clock |
| rst | input | 1 | Synchronous active-high reset, sampled on `ref_clk` |
| cfg_disable | input | 1 | 1 = monitor off (configuration bit) |
| irq_clr | input | 1 | Write-one-to-clear strobe for `irq` |
| sys_clk | output | 1 | Glitch-free system clock (external or reference) |
| src_is_ref | output | 1 | Sticky: 1 once the reference clock is the source |
| osc_en | output | 1 | Enable for the reference oscillator |
| irq | output | 1 | Failure interrupt request flag |

## Verification
The assertions assume that the reference clock keeps running. They also assume that `cfg_disable` and `irq_clr` change only between reference edges, and that each level of a live external clock lasts longer than one reference period, so that no transition is lost in sampling. The stimulus drives every input on the falling reference edge. It never holds an external level for less than two reference cycles, except when it stops the external clock on purpose to cause a failure. The gaps between transitions are chosen to sit just inside and just outside the 16-cycle limit. A behavioural model in the bench predicts every output on every reference cycle, including the two-cycle dead time of `sys_clk` during the switchover.

// File: rtl/owd_pkg.sv
package owd_pkg;

    typedef enum logic {
        SRC_EXT = 1'b0,
        SRC_REF = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic failed;
        logic fail_now;
    } owd_status_t;

    function automatic int cnt_bits(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/owd_edge_detect.sv
module owd_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic toggle
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[g] <= 1'b0;
                else     sync_q[g] <= sync_q[g-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= 1'b0;
        else     last_q <= sync_q[SYNC_STAGES-1];
    end

    assign toggle = sync_q[SYNC_STAGES-1] ^ last_q;
endmodule

// File: rtl/owd_timeout.sv
module owd_timeout
    import owd_pkg::*;
#(
    parameter int TIMEOUT = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         enable,
    input  logic                         clear,
    output owd_status_t                  status,
    output logic [cnt_bits(TIMEOUT)-1:0] count
);
    localparam int CW = cnt_bits(TIMEOUT);
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);
    localparam logic [CW-1:0] SAT  = CW'(TIMEOUT);

    logic [CW-1:0] cnt_q;
    logic          failed_q;
    logic          expire;

    assign expire = !failed_q && enable && !clear && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            failed_q <= 1'b0;
        end else if (!failed_q) begin
            if (!enable || clear) begin
                cnt_q <= '0;
            end else if (cnt_q == LAST) begin
                cnt_q    <= SAT;
                failed_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign status.failed   = failed_q;
    assign status.fail_now = expire;
    assign count           = cnt_q;
endmodule

// File: rtl/owd_clk_switch.sv
module owd_clk_switch
    import owd_pkg::*;
#(
    parameter int GATE_STAGES = 2
) (
    input  logic     ref_clk,
    input  logic     ext_clk,
    input  logic     rst,
    input  clk_src_e src,
    output logic     ext_gate,
    output logic     ref_gate,
    output logic     sys_clk
);
    logic [GATE_STAGES-1:0] gate_q;

    // The external path closes only after the external clock has been
    // static for the full timeout, so closing it cannot cut a pulse short.
    assign ext_gate = (src == SRC_EXT);

    for (genvar g = 0; g < GATE_STAGES; g++) begin : g_gate
        if (g == 0) begin : g_first
            always_ff @(negedge ref_clk) begin
                if (rst) gate_q[0] <= 1'b0;
                else     gate_q[0] <= (src == SRC_REF);
            end
        end else begin : g_next
            always_ff @(negedge ref_clk) begin
                if (rst) gate_q[g] <= 1'b0;
                else     gate_q[g] <= gate_q[g-1];
            end
        end
    end

    assign ref_gate = gate_q[GATE_STAGES-1];
    assign sys_clk  = (ext_clk & ext_gate) | (ref_clk & ref_gate);
endmodule

// File: rtl/owd_monitor.sv
module owd_monitor
    import owd_pkg::*;
#(
    parameter int TIMEOUT     = 16,
    parameter int SYNC_STAGES = 2,
    parameter int GATE_STAGES = 2
) (
    input  logic ref_clk,
    input  logic ext_clk,
    input  logic rst,
    input  logic cfg_disable,
    input  logic irq_clr,
    output logic sys_clk,
    output logic src_is_ref,
    output logic osc_en,
    output logic irq
);
    localparam int CW = cnt_bits(TIMEOUT);

    logic          ext_toggle;
    owd_status_t   status;
    logic [CW-1:0] tmo_count;
    clk_src_e      src;
    logic          ext_gate;
    logic          ref_gate;
    logic          irq_q;

    owd_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk      (ref_clk),
        .rst      (rst),
        .async_in (ext_clk),
        .toggle   (ext_toggle)
    );

    owd_timeout #(.TIMEOUT(TIMEOUT)) u_tmo (
        .clk    (ref_clk),
        .rst    (rst),
        .enable (!cfg_disable),
        .clear  (ext_toggle),
        .status (status),
        .count  (tmo_count)
    );

    assign src = status.failed ? SRC_REF : SRC_EXT;

    owd_clk_switch #(.GATE_STAGES(GATE_STAGES)) u_sw (
        .ref_clk  (ref_clk),
        .ext_clk  (ext_clk),
        .rst      (rst),
        .src      (src),
        .ext_gate (ext_gate),
        .ref_gate (ref_gate),
        .sys_clk  (sys_clk)
    );

    always_ff @(posedge ref_clk) begin
        if (rst)                  irq_q <= 1'b0;
        else if (status.fail_now) irq_q <= 1'b1;
        else if (irq_clr)         irq_q <= 1'b0;
    end

    assign irq        = irq_q;
    assign src_is_ref = (src == SRC_REF);
    assign osc_en     = !cfg_disable || status.failed;
endmodule

// File: rtl/owd_monitor_chk.sv
module owd_monitor_chk #(
    parameter int CW      = 5,
    parameter int TIMEOUT = 16
) (
    input logic          ref_clk,
    input logic          rst,
    input logic          cfg_disable,
    input logic          irq_clr,
    input logic          src_is_ref,
    input logic          osc_en,
    input logic          irq,
    input logic          ext_gate,
    input logic [CW-1:0] tmo_count
);
    a_r5_sticky_source: assert property (@(posedge ref_clk) disable iff (rst)
        src_is_ref |=> src_is_ref);

    a_r6_irq_on_failure: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(src_is_ref) |-> irq);

    a_r6_irq_holds: assert property (@(posedge ref_clk) disable iff (rst)
        (irq && !irq_clr) |=> irq);

    a_r7_clear_keeps_src: assert property (@(posedge ref_clk) disable iff (rst)
        (irq_clr && src_is_ref) |=> src_is_ref);

    a_r3_disabled_no_fail: assert property (@(posedge ref_clk) disable iff (rst)
        (cfg_disable && !src_is_ref) |=> !src_is_ref);

    a_r9_osc_kept_on: assert property (@(posedge ref_clk) disable iff (rst)
        src_is_ref |-> osc_en);

    a_r8_ext_gated_after_fail: assert property (@(posedge ref_clk) disable iff (rst)
        src_is_ref |-> !ext_gate);

    a_r4_count_bounded: assert property (@(posedge ref_clk) disable iff (rst)
        tmo_count <= CW'(TIMEOUT));
endmodule

bind owd_monitor owd_monitor_chk #(.CW(CW), .TIMEOUT(TIMEOUT)) u_chk (
    .ref_clk     (ref_clk),
    .rst         (rst),
    .cfg_disable (cfg_disable),
    .irq_clr     (irq_clr),
    .src_is_ref  (src_is_ref),
    .osc_en      (osc_en),
    .irq         (irq),
    .ext_gate    (ext_gate),
    .tmo_count   (tmo_count)
);

// File: tb/test_owd_monitor.sv
`timescale 1ns/1ps
module test_owd_monitor;
    logic ref_clk = 1'b0;
    logic ext_clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_disable = 1'b0;
    logic irq_clr = 1'b0;
    logic sys_clk, src_is_ref, osc_en, irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 ref_clk = ~ref_clk;   // 50 MHz

    owd_monitor i_owd_monitor (
        .ref_clk(ref_clk), .ext_clk(ext_clk), .rst(rst),
        .cfg_disable(cfg_disable), .irq_clr(irq_clr),
        .sys_clk(sys_clk), .src_is_ref(src_is_ref),
        .osc_en(osc_en), .irq(irq)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // behavioural reference model, evaluated on every reference edge
    int hist[$];
    int m_cnt = 0;
    int m_age = 0;
    bit m_fail = 0;
    bit m_irq = 0;

    always @(posedge ref_clk) begin
        bit tog, set_now, exp_sys;
        if (rst) begin
            hist = '{0, 0, 0};
            m_cnt = 0; m_fail = 0; m_irq = 0; m_age = 0;
        end else begin
            tog = (hist[1] != hist[0]);
            hist.push_back(int'(ext_clk));
            void'(hist.pop_front());
            set_now = 0;
            if (!m_fail) begin
                if (cfg_disable || tog) m_cnt = 0;
                else if (m_cnt == 15) begin m_fail = 1; set_now = 1; end
                else m_cnt++;
            end
            if (m_fail && !set_now) m_age++;
            if (set_now) m_irq = 1;
            else if (irq_clr) m_irq = 0;
        end
        #5;
        if (!rst) begin
            check("R4 src_is_ref", src_is_ref, m_fail);
            check("R6 irq", irq, m_irq);
            check("R3 osc_en", osc_en, !cfg_disable || m_fail);
            exp_sys = m_fail ? (m_age >= 2) : ext_clk;
            check("R8 sys_clk", sys_clk, exp_sys);
        end
    end

    task automatic run_ext(input int half, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge ref_clk);
            if (i % half == half - 1) ext_clk = ~ext_clk;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge ref_clk);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle(4);
        rst = 1'b0;
        @(negedge ref_clk);
        check("R1 src after reset", src_is_ref, 1'b0);
        check("R1 irq after reset", irq, 1'b0);
        check("R1 osc_en after reset", osc_en, 1'b1);

        run_ext(2, 60);                      // fast clock
        run_ext(16, 80);                     // gap exactly at the limit
        check("R2 no failure at gap 16", src_is_ref, 1'b0);

        cfg_disable = 1'b1;
        idle(40);
        check("R3 disabled osc_en", osc_en, 1'b0);
        check("R3 disabled no failure", src_is_ref, 1'b0);
        cfg_disable = 1'b0;
        run_ext(3, 12);

        idle(30);                            // external clock stops low
        check("R4 failure declared", src_is_ref, 1'b1);
        check("R6 irq raised", irq, 1'b1);

        run_ext(2, 40);                      // clock comes back
        check("R5 stays on reference", src_is_ref, 1'b1);

        irq_clr = 1'b1;
        @(negedge ref_clk);
        irq_clr = 1'b0;
        check("R6 irq cleared", irq, 1'b0);
        check("R7 source unchanged by clear", src_is_ref, 1'b1);

        cfg_disable = 1'b1;
        idle(5);
        check("R9 osc_en kept", osc_en, 1'b1);
        check("R9 source kept", src_is_ref, 1'b1);
        cfg_disable = 1'b0;

        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        run_ext(2, 20);
        check("R10 back on external", src_is_ref, 1'b0);

        run_ext(17, 20);                     // one gap of 17 cycles
        check("R4 failure at gap 17", src_is_ref, 1'b1);

        rst = 1'b1;
        idle(3);
        rst = 1'b0;
        ext_clk = 1'b1;
        run_ext(2, 10);
        ext_clk = 1'b1;
        idle(25);                            // stuck high
        check("R8 failure with stuck-high clock", src_is_ref, 1'b1);
        idle(3);
        finish_run();
    end
endmodule